// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master for a three-wire serial digital-to-analog converter. A client hands it a 2-bit operating mode and a 10-bit output code over a valid/ready handshake. The controller packs them into one 16-bit word. It opens a frame with a falling edge on the frame-select line and shifts the word out MSB first on a divided serial clock. It then holds frame-select high for a programmable minimum gap before it will take another request.

The serial clock idles low. The data line changes only on rising clock edges, so each bit is stable when the converter samples it on the falling edge (clock polarity 0, phase 1). Between frames all three lines rest low, which keeps the converter's input current small. Frame-select is raised for one serial half-period just before a frame, so that every frame begins with a fresh falling edge. The serial clock period is an even number of system clocks, `2*SCLK_HALF`. With a 100 MHz system clock the default of 2 gives 25 MHz, which stays below the 30 MHz limit.

Top module: `dacw_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `ser_frame`, `ser_clk`, `ser_data`, `busy` and `done` are low, and `req_ready` is high once the block is idle.
- R2: Each frame carries the word {2'b00, mode[1:0], code[9:0], 2'b00}, MSB first (bits 15:14 zero, bits 13:12 mode, bits 11:2 code, bits 1:0 zero). Mode 00 is normal output, 01 is power-down with the 1k pull-down, 10 is power-down with the 100k pull-down, and 11 is power-down with high impedance.
- R3: While `ser_frame` is low, exactly 16 falling edges of `ser_clk` occur, and `ser_clk` is never high while `ser_frame` is high.
- R4: `ser_data` changes only while `ser_clk` is low or at its rising edge, and never while `ser_clk` stays high.
- R5: Every high phase and every low phase of `ser_clk` inside a frame lasts exactly `SCLK_HALF` system clocks.
- R6: After the 16th falling edge, `ser_frame` is high for exactly `GAP_CYCLES` system clocks and then returns low.
- R7: `req_ready` is low from the cycle after a request is accepted until the gap has elapsed. An accepted request makes `busy` and `ser_frame` high in the next cycle.
- R8: `done` is a single-cycle pulse, exactly one per frame, raised in the cycle in which the 16th falling edge appears on `ser_clk`.
- R9: When no frame is in progress, `ser_frame`, `ser_clk` and `ser_data` are all low.
- R10: Before each frame, `ser_frame` is high for exactly `SCLK_HALF` system clocks, and `ser_data` is low whenever `ser_frame` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_mode | input | 2 | Operating mode for the converter |
| req_code | input | 10 | Output code, straight binary |
| busy | output | 1 | A frame or its gap is in progress |
| done | output | 1 | One-cycle pulse on the last falling edge of a frame |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_frame | output | 1 | Frame select, active low during a frame |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
The bench sends all 1024 codes, each paired with a mode that cycles through all four values, and decodes every frame from the serial lines. This shows whether the code and the mode land in the right bit positions. Words of all ones, all zeros and the alternating patterns 0x2AA and 0x155 follow, sent with every mode. These catch a stuck bit, a shift that runs one position off, and a swap of adjacent bits. Most requests arrive back to back with valid held high, while some follow an idle pause. This separates a correct gap and lead-in length from one that depends on when the request arrives, and it confirms that the lines rest low between frames.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  localparam int FRAME_W = 16;
  localparam int MODE_W  = 2;
  localparam int CODE_W  = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } dacw_state_e;

  function automatic logic [FRAME_W-1:0] dacw_word(input logic [MODE_W-1:0] m,
                                                   input logic [CODE_W-1:0] c);
    return {2'b00, m, c, 2'b00};
  endfunction
endpackage

// File: rtl/dacw_tick.sv
module dacw_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise,
  input  logic         fall,
  output logic         msb,
  output logic         last_fall
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] fcnt_q, fcnt_d;

  assign msb       = sh_q[W-1];
  assign last_fall = fall && (fcnt_q == CW'(W - 1));

  always_comb begin
    sh_d   = sh_q;
    fcnt_d = fcnt_q;
    if (load) begin
      sh_d   = load_val;
      fcnt_d = '0;
    end else begin
      if (rise && (fcnt_q != '0)) sh_d = {sh_q[W-2:0], 1'b0};
      if (fall) fcnt_d = last_fall ? '0 : fcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      fcnt_q <= '0;
    end else begin
      sh_q   <= sh_d;
      fcnt_q <= fcnt_d;
    end
  end
endmodule

// File: rtl/dacw_gap.sv
module dacw_gap #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = en && (cnt_q == CW'(CYC - 1));

  always_comb begin
    if (!en || expire) cnt_d = '0;
    else               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl
  import dacw_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int GAP_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [CODE_W-1:0] req_code,
  output logic              busy,
  output logic              done,
  output logic              ser_clk,
  output logic              ser_frame,
  output logic              ser_data
);
  logic [1:0]  rsync_q;
  logic        rst_ni;
  dacw_state_e state_q, state_d;
  logic        sclk_q, sclk_d;
  logic        frame_q, frame_d;
  logic        done_q;
  logic        tick, rise, fall, msb, last_fall, gap_exp, accept, tick_en;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign req_ready = (state_q == ST_IDLE) && rst_ni;
  assign accept    = req_valid && req_ready;
  assign busy      = (state_q != ST_IDLE);
  assign tick_en   = (state_q == ST_ARM) || (state_q == ST_SHIFT);
  assign rise      = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign fall      = (state_q == ST_SHIFT) && tick && sclk_q;

  dacw_tick #(.HALF(SCLK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_ni), .en(tick_en), .tick(tick)
  );

  dacw_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .load(accept),
    .load_val(dacw_word(req_mode, req_code)),
    .rise(rise), .fall(fall), .msb(msb), .last_fall(last_fall)
  );

  dacw_gap #(.CYC(GAP_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_ni), .en(state_q == ST_GAP), .expire(gap_exp)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)    state_d = ST_ARM;
      ST_ARM:   if (tick)      state_d = ST_SHIFT;
      ST_SHIFT: if (last_fall) state_d = ST_GAP;
      ST_GAP:   if (gap_exp)   state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
    sclk_d  = (state_q == ST_SHIFT) ? (sclk_q ^ tick) : 1'b0;
    frame_d = (state_d == ST_ARM) || (state_d == ST_GAP);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      frame_q <= frame_d;
      done_q  <= last_fall;
    end
  end

  assign ser_clk   = sclk_q;
  assign ser_frame = frame_q;
  assign ser_data  = (state_q == ST_SHIFT) && msb;
  assign done      = done_q;
endmodule

// File: rtl/dacw_ctrl_chk.sv
module dacw_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_clk,
  input logic ser_frame,
  input logic ser_data
);
  p_din_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  p_clk_outside_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !ser_frame);

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_frame && !ser_clk && !ser_data));

  p_accept_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && ser_frame && !req_ready));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_on_last_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ser_frame && !ser_clk && $past(ser_clk)));

  p_data_low_when_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ser_frame |-> !ser_data);
endmodule

bind dacw_ctrl dacw_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ser_clk(ser_clk), .ser_frame(ser_frame),
  .ser_data(ser_data)
);

// File: tb/dacw_ctrl_test.sv
module dacw_ctrl_test;
  localparam int HALF = 2;
  localparam int GAP  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = '0;
  logic [9:0] req_code = '0;
  logic       req_ready, busy, done, ser_clk, ser_frame, ser_data;

  int vectors = 0;
  int fails = 0;
  int frames_rx = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  logic [15:0] expq[$];

  always #5 clk = ~clk;

  dacw_ctrl #(.SCLK_HALF(HALF), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_code(req_code), .busy(busy), .done(done),
    .ser_clk(ser_clk), .ser_frame(ser_frame), .ser_data(ser_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial monitor: 0 idle, 1 lead-in, 2 frame, 3 gap
  int          ph = 0;
  int          hi_len = 0;
  int          run = 0;
  int          falls = 0;
  logic [15:0] word = '0;
  logic        p_clk = 1'b0;
  logic        p_data = 1'b0;
  bit          mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (done) done_cnt++;
      case (ph)
        0: begin
          if (ser_frame) begin
            ph = 1; hi_len = 1;
            chk(!ser_data && !ser_clk, "R10", {ser_data, ser_clk}, 0);
          end else if (ser_clk || ser_data)
            chk(1'b0, "R9", {ser_clk, ser_data}, 0);
        end
        1: begin
          chk(!req_ready, "R7", req_ready, 0);
          if (ser_frame) begin
            hi_len++;
            if (ser_data || ser_clk) chk(1'b0, "R10", {ser_data, ser_clk}, 0);
          end else begin
            chk(hi_len == HALF, "R10", hi_len, HALF);
            ph = 2; run = 1; falls = 0; word = '0;
            chk(!ser_clk, "R3", ser_clk, 0);
          end
        end
        2: begin
          if (ser_clk != p_clk) begin
            if (run != HALF) chk(1'b0, "R5", run, HALF);
            run = 1;
            if (p_clk && !ser_clk) begin
              falls++;
              word = {word[14:0], p_data};
            end
          end else begin
            run++;
            if (ser_clk && ser_data != p_data) chk(1'b0, "R4", ser_data, p_data);
          end
          if (!req_ready) ; else chk(1'b0, "R7", req_ready, 0);
          if (ser_frame) begin
            logic [15:0] e;
            e = (expq.size() > 0) ? expq.pop_front() : 16'hxxxx;
            frames_rx++;
            chk(falls == 16, "R3", falls, 16);
            chk(word === e, "R2", word, e);
            chk(done, "R8", done, 1);
            chk(!ser_data, "R10", ser_data, 0);
            ph = 3; hi_len = 1;
          end else if (done) chk(1'b0, "R8", done, 0);
        end
        default: begin
          if (ser_frame) begin
            hi_len++;
            if (req_ready || ser_clk || ser_data)
              chk(1'b0, "R7", {req_ready, ser_clk, ser_data}, 0);
          end else begin
            chk(hi_len == GAP, "R6", hi_len, GAP);
            chk(req_ready, "R7", req_ready, 1);
            chk(!ser_clk && !ser_data, "R9", {ser_clk, ser_data}, 0);
            ph = 0;
          end
        end
      endcase
      p_clk  = ser_clk;
      p_data = ser_data;
    end
  end

  task automatic send(input logic [1:0] m, input logic [9:0] c);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_code = c;
    while (!req_ready) @(negedge clk);
    expq.push_back({2'b00, m, c, 2'b00});
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ser_frame && !ser_clk && !ser_data && !busy && !done, "R1",
        {ser_frame, ser_clk, ser_data, busy, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !busy && !ser_frame && !ser_clk && !ser_data, "R1",
        {req_ready, busy, ser_frame, ser_clk, ser_data}, 5'b10000);
    mon_en = 1'b1;
    for (int k = 0; k < 1024; k++) begin
      send(2'(k), 10'(k));
      if (k % 64 == 63) repeat (7) @(negedge clk);
    end
    for (int m = 0; m < 4; m++) begin
      send(2'(m), 10'h3FF);
      send(2'(m), 10'h000);
      send(2'(m), 10'h2AA);
      send(2'(m), 10'h155);
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(frames_rx == 1040, "R2", frames_rx, 1040);
    chk(done_cnt == frames_rx, "R8", done_cnt, frames_rx);
    chk(expq.size() == 0, "R3", expq.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", frames_rx, 1040);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule